// File: doc/BRIEF.md
# Buffered Transfer Count Controller

This block sits between a host register port and a byte-level serial engine and runs multi-byte transfers out of a small byte buffer. The host loads a count register, whose low seven bits give the number of bytes and whose top bit decides whether the last received byte is refused. For a transmit, the host then fills the buffer through a data register. A start command checks the count and, if the count is usable, hands the buffer to the serial engine.

During a transfer the serial engine reads the byte to send from the current pointer in the same cycle. Each byte-done pulse moves the pointer on by one. For a receive, the block stores the incoming byte and tells the engine, one cycle ahead, whether to acknowledge it. The transfer ends on one of three events: the count is reached, the far end refuses a transmitted byte, or a stop is seen while receiving. At the end the block raises an interrupt, writes a status code and stores the number of bytes actually moved in the count field. It also rewinds the pointer to zero, so the host can read the received bytes starting from the first one.

Top module: `xfer_count_ctrl`

## Requirements
- R1: After reset, status reads F8h, irq and busy are 0, and the count register reads 00h.
- R2: A count write stores all 8 bits and reads back unchanged. Bits [6:0] are the byte count and bit 7 is the refuse-last-byte flag. A count write also rewinds the buffer pointer to 0.
- R3: In idle, each host data write stores a byte at the pointer and advances the pointer. A data write with the pointer at or past the programmed count stores nothing and leaves the pointer where it is.
- R4: A start while the count field is 0 or greater than 68 starts no transfer. One cycle later irq is 1, busy is 0 and status is FCh.
- R5: A start with a count from 1 to 68 sets busy and clears irq one cycle later, with the pointer at 0. The transfer is a receive when dir_rx is 1 and a transmit when it is 0.
- R6: In transmit, eng_tx_byte shows the buffer byte at the pointer combinationally, and every eng_done pulse advances the pointer.
- R7: A transmit in which every byte is acknowledged (eng_nack_in = 0) ends on the done pulse of the byte whose number equals the count, with status 28h.
- R8: A transmit byte reported refused (eng_nack_in = 1) ends the transfer on that pulse with status 30h. The count field then holds the number of bytes sent, including the refused one.
- R9: In receive, bytes are stored in arrival order. With bit 7 of the count at 0, eng_nack_out stays 0 for every byte. With bit 7 at 1, eng_nack_out is 1 only while the final byte of the count is pending.
- R10: A receive that reaches the count ends with status 50h when bit 7 is 0 and 58h when bit 7 is 1.
- R11: An eng_stop pulse during a receive, with no eng_done in the same cycle, ends the transfer with status A0h. The count field then holds the number of bytes received.
- R12: At the end of any transfer, busy falls and irq rises. The pointer returns to 0, the count field holds the number of bytes moved, and bit 7 is kept. Each host data read returns the byte at the pointer and advances it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cnt_we | input | 1 | Count register write strobe |
| host_cnt_wdata | input | 8 | Count register write value |
| host_cnt_rdata | output | 8 | Count register read value |
| host_dat_we | input | 1 | Data register write strobe |
| host_dat_wdata | input | 8 | Data byte to store |
| host_dat_re | input | 1 | Data register read strobe (advances pointer) |
| host_dat_rdata | output | 8 | Buffer byte at the pointer |
| start | input | 1 | Start command |
| dir_rx | input | 1 | Direction for the start: 1 receive, 0 transmit |
| eng_tx_byte | output | 8 | Byte for the serial engine to send |
| eng_done | input | 1 | One byte finished on the serial side |
| eng_nack_in | input | 1 | Transmitted byte was refused |
| eng_rx_byte | input | 8 | Received byte, valid with eng_done |
| eng_stop | input | 1 | Stop seen during a receive |
| eng_nack_out | output | 1 | Refuse the byte now being received |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer finished or count rejected |
| status | output | 8 | Status code |

## Verification
Transmit runs use random lengths across the full 1 to 68 range, each either fully acknowledged or refused at a random byte. This separates end-on-count from early end, and shows whether the reported byte count includes the refused byte. Receive runs vary the refuse-last flag and sometimes insert a stop at a random byte. These runs separate the 50h, 58h and A0h endings, and they show whether eng_nack_out marks exactly the last byte. Directed cases cover counts of 0, 69 and 127, lengths of 1 and 68, and surplus host writes whose effect shows up when the buffer is read back.

// File: rtl/xcc_pkg.sv
// Shared types for the buffered transfer count controller.
// Status codes are read by software, so their values are fixed.
package xcc_pkg;

    typedef enum logic [7:0] {
        ST_IDLE         = 8'hF8,
        ST_BAD_COUNT    = 8'hFC,
        ST_TX_ALL_ACKED = 8'h28,
        ST_TX_REFUSED   = 8'h30,
        ST_RX_FULL_ACK  = 8'h50,
        ST_RX_FULL_NACK = 8'h58,
        ST_RX_STOPPED   = 8'hA0
    } xfer_status_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } xfer_phase_e;

endpackage

// File: rtl/xcc_buffer.sv
// Byte store for the transfer buffer.
// One synchronous write port and one combinational read port, so a byte
// can be read in the same cycle it is addressed.
// Assumes: wr_addr is below DEPTH whenever wr_en is high.
module xcc_buffer #(
    parameter int DEPTH = 68,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    // Store one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Combinational read, zero for out-of-range addresses.
    always_comb begin
        if (32'(rd_addr) < DEPTH) begin
            rd_data = mem[rd_addr];
        end else begin
            rd_data = '0;
        end
    end

    // R3: no write ever lands outside the buffer.
    assert_wr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < DEPTH));

endmodule

// File: rtl/xcc_count_check.sv
// Count validator: a byte count is usable when it is 1 to DEPTH.
// Pure combinational logic; it is evaluated against the stored count register.
module xcc_count_check #(
    parameter int DEPTH = 68,
    parameter int CW    = 7
) (
    input  logic [CW-1:0] count_field,
    output logic          count_ok
);

    // Range test of the programmed count.
    always_comb begin
        count_ok = (count_field != '0) && (32'(count_field) <= DEPTH);
    end

endmodule

// File: rtl/xcc_seq.sv
// Transfer sequencer: holds the count register, the shared buffer pointer,
// the status code and the interrupt. It moves the pointer for host accesses
// in idle and for serial-side byte events during a transfer.
// Assumes: count_ok reflects cnt_q; eng_* inputs are single-cycle pulses.
module xcc_seq
    import xcc_pkg::*;
#(
    parameter int DEPTH = 68,
    parameter int CW    = 7,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cnt_we,
    input  logic [CW:0]   host_cnt_wdata,
    input  logic          host_dat_we,
    input  logic          host_dat_re,
    input  logic          start,
    input  logic          dir_rx,
    input  logic          count_ok,
    input  logic          eng_done,
    input  logic          eng_nack_in,
    input  logic          eng_stop,
    output logic [AW-1:0] ptr,
    output logic          buf_we,
    output logic          buf_from_engine,
    output logic [CW:0]   cnt_q,
    output logic [7:0]    status,
    output logic          irq,
    output logic          busy,
    output logic          eng_nack_out
);

    xfer_phase_e  phase_q;
    xfer_status_e status_q;
    logic         rx_q;

    logic         last_byte;
    logic         host_wr_ok;
    logic         fin;
    logic         adv;
    xfer_status_e fin_status;
    logic [CW-1:0] fin_count;

    assign busy   = (phase_q == PH_RUN);
    assign status = status_q;

    // Pointer sits on the final byte of the programmed count.
    always_comb begin
        last_byte = (32'(ptr) + 1 == 32'(cnt_q[CW-1:0]));
    end

    // Host data write is accepted only below the count and inside the buffer.
    always_comb begin
        host_wr_ok = !busy && !start && !host_cnt_we && host_dat_we &&
                     (32'(ptr) < 32'(cnt_q[CW-1:0])) && (32'(ptr) < DEPTH);
    end

    // Buffer write select: engine bytes while receiving, host bytes in idle.
    always_comb begin
        buf_from_engine = busy && rx_q && eng_done;
        buf_we          = buf_from_engine || host_wr_ok;
    end

    // Refuse the pending received byte when it is the last and the flag is set.
    always_comb begin
        eng_nack_out = busy && rx_q && cnt_q[CW] && last_byte;
    end

    // Decide whether this cycle ends the transfer, and with what result.
    always_comb begin
        fin        = 1'b0;
        adv        = 1'b0;
        fin_status = ST_IDLE;
        fin_count  = CW'(32'(ptr) + 1);
        if (busy) begin
            if (eng_done) begin
                if (rx_q) begin
                    if (last_byte) begin
                        fin        = 1'b1;
                        fin_status = cnt_q[CW] ? ST_RX_FULL_NACK : ST_RX_FULL_ACK;
                    end else begin
                        adv = 1'b1;
                    end
                end else if (eng_nack_in) begin
                    fin        = 1'b1;
                    fin_status = ST_TX_REFUSED;
                end else if (last_byte) begin
                    fin        = 1'b1;
                    fin_status = ST_TX_ALL_ACKED;
                end else begin
                    adv = 1'b1;
                end
            end else if (rx_q && eng_stop) begin
                fin        = 1'b1;
                fin_status = ST_RX_STOPPED;
                fin_count  = CW'(ptr);
            end
        end
    end

    // Phase, pointer, count, status and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            ptr      <= '0;
            cnt_q    <= '0;
            status_q <= ST_IDLE;
            irq      <= 1'b0;
            rx_q     <= 1'b0;
        end else if (busy) begin
            if (fin) begin
                phase_q          <= PH_IDLE;
                ptr              <= '0;
                cnt_q[CW-1:0]    <= fin_count;
                status_q         <= fin_status;
                irq              <= 1'b1;
            end else if (adv) begin
                ptr <= ptr + 1'b1;
            end
        end else if (start) begin
            ptr <= '0;
            if (count_ok) begin
                phase_q  <= PH_RUN;
                irq      <= 1'b0;
                rx_q     <= dir_rx;
                status_q <= ST_IDLE;
            end else begin
                irq      <= 1'b1;
                status_q <= ST_BAD_COUNT;
            end
        end else if (host_cnt_we) begin
            cnt_q <= host_cnt_wdata;
            ptr   <= '0;
        end else if (host_wr_ok) begin
            ptr <= ptr + 1'b1;
        end else if (host_dat_re && (32'(ptr) < DEPTH - 1)) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R4: an unusable count is rejected with the dedicated status.
    assert_bad_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !count_ok) |=> (irq && !busy && status == 8'hFC));

    // R5: a usable count starts a transfer from the first byte.
    assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && count_ok) |=> (busy && !irq && ptr == '0));

    // R6: the pointer never walks past the programmed count while running.
    assert_run_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(ptr) < 32'(cnt_q[CW-1:0])));

    // R8: a refused transmit byte ends the transfer at once.
    assert_tx_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rx_q && eng_done && eng_nack_in) |=> (!busy && status == 8'h30));

    // R9: a byte refused by this block is always the one that ends the receive.
    assert_nack_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && eng_nack_out) |=> (!busy && irq));

    // R12: every end of transfer rewinds the pointer and raises the interrupt.
    assert_rewind_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ptr == '0 && irq));

endmodule

// File: rtl/xfer_count_ctrl.sv
// Buffered transfer count controller, top level.
// Joins the byte store, the count validator and the sequencer. The byte the
// host reads and the byte the serial engine sends both come from the buffer
// entry at the shared pointer.
// Assumes: a single clock domain with the serial engine.
module xfer_count_ctrl #(
    parameter int DEPTH = 68,
    parameter int DW    = 8,
    parameter int CW    = 7,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cnt_we,
    input  logic [CW:0]   host_cnt_wdata,
    output logic [CW:0]   host_cnt_rdata,
    input  logic          host_dat_we,
    input  logic [DW-1:0] host_dat_wdata,
    input  logic          host_dat_re,
    output logic [DW-1:0] host_dat_rdata,
    input  logic          start,
    input  logic          dir_rx,
    output logic [DW-1:0] eng_tx_byte,
    input  logic          eng_done,
    input  logic          eng_nack_in,
    input  logic [DW-1:0] eng_rx_byte,
    input  logic          eng_stop,
    output logic          eng_nack_out,
    output logic          busy,
    output logic          irq,
    output logic [7:0]    status
);

    logic [AW-1:0] ptr;
    logic          buf_we;
    logic          buf_from_engine;
    logic [DW-1:0] buf_wdata;
    logic [DW-1:0] buf_rdata;
    logic [CW:0]   cnt_q;
    logic          count_ok;

    // Byte source for the buffer write port.
    always_comb begin
        buf_wdata = buf_from_engine ? eng_rx_byte : host_dat_wdata;
    end

    assign host_cnt_rdata = cnt_q;
    assign host_dat_rdata = buf_rdata;
    assign eng_tx_byte    = buf_rdata;

    xcc_buffer #(.DEPTH(DEPTH), .DW(DW)) u_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_addr (ptr),
        .wr_data (buf_wdata),
        .rd_addr (ptr),
        .rd_data (buf_rdata)
    );

    xcc_count_check #(.DEPTH(DEPTH), .CW(CW)) u_check (
        .count_field (cnt_q[CW-1:0]),
        .count_ok    (count_ok)
    );

    xcc_seq #(.DEPTH(DEPTH), .CW(CW)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_cnt_we     (host_cnt_we),
        .host_cnt_wdata  (host_cnt_wdata),
        .host_dat_we     (host_dat_we),
        .host_dat_re     (host_dat_re),
        .start           (start),
        .dir_rx          (dir_rx),
        .count_ok        (count_ok),
        .eng_done        (eng_done),
        .eng_nack_in     (eng_nack_in),
        .eng_stop        (eng_stop),
        .ptr             (ptr),
        .buf_we          (buf_we),
        .buf_from_engine (buf_from_engine),
        .cnt_q           (cnt_q),
        .status          (status),
        .irq             (irq),
        .busy            (busy),
        .eng_nack_out    (eng_nack_out)
    );

endmodule

// File: tb/sim_xfer_count_ctrl.sv
// Bench for the buffered transfer count controller: directed corners plus
// seeded random transmit and receive runs against a byte model of the buffer.
module sim_xfer_count_ctrl;

    localparam int DEPTH = 68;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cnt_we = 1'b0;
    logic [7:0] host_cnt_wdata = '0;
    logic [7:0] host_cnt_rdata;
    logic       host_dat_we = 1'b0;
    logic [7:0] host_dat_wdata = '0;
    logic       host_dat_re = 1'b0;
    logic [7:0] host_dat_rdata;
    logic       start = 1'b0;
    logic       dir_rx = 1'b0;
    logic [7:0] eng_tx_byte;
    logic       eng_done = 1'b0;
    logic       eng_nack_in = 1'b0;
    logic [7:0] eng_rx_byte = '0;
    logic       eng_stop = 1'b0;
    logic       eng_nack_out;
    logic       busy;
    logic       irq;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    xfer_count_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .host_cnt_we(host_cnt_we), .host_cnt_wdata(host_cnt_wdata),
        .host_cnt_rdata(host_cnt_rdata),
        .host_dat_we(host_dat_we), .host_dat_wdata(host_dat_wdata),
        .host_dat_re(host_dat_re), .host_dat_rdata(host_dat_rdata),
        .start(start), .dir_rx(dir_rx), .eng_tx_byte(eng_tx_byte),
        .eng_done(eng_done), .eng_nack_in(eng_nack_in),
        .eng_rx_byte(eng_rx_byte), .eng_stop(eng_stop),
        .eng_nack_out(eng_nack_out), .busy(busy), .irq(irq), .status(status)
    );

    function automatic logic [7:0] f_tx_status(bit refused);
        return refused ? 8'h30 : 8'h28;
    endfunction

    function automatic logic [7:0] f_rx_status(bit full, bit lb);
        if (!full) return 8'hA0;
        return lb ? 8'h58 : 8'h50;
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_cnt(logic [7:0] v);
        host_cnt_we = 1'b1; host_cnt_wdata = v;
        @(negedge clk);
        host_cnt_we = 1'b0;
    endtask

    task automatic wr_dat(logic [7:0] v);
        host_dat_we = 1'b1; host_dat_wdata = v;
        @(negedge clk);
        host_dat_we = 1'b0;
    endtask

    task automatic rd_dat(output logic [7:0] v);
        v = host_dat_rdata;
        host_dat_re = 1'b1;
        @(negedge clk);
        host_dat_re = 1'b0;
    endtask

    task automatic do_start(bit rx);
        start = 1'b1; dir_rx = rx;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic end_checks(string req, logic [7:0] exp_st, logic [7:0] exp_cnt);
        check8("R12 busy", {7'd0, busy}, 8'd0);
        check8("R12 irq", {7'd0, irq}, 8'd1);
        check8(req, status, exp_st);
        check8("R12 count", host_cnt_rdata, exp_cnt);
    endtask

    // Transmit n bytes; refuse_at < 0 means every byte is acknowledged.
    task automatic run_tx(int n, int refuse_at);
        logic [7:0] b;
        int sent;
        wr_cnt(8'(n));
        for (int i = 0; i < n; i++) begin
            model[i] = 8'($urandom);
            wr_dat(model[i]);
        end
        wr_dat(8'hEE);  // beyond the count: must be ignored
        do_start(1'b0);
        check8("R5 busy", {7'd0, busy}, 8'd1);
        check8("R5 irq", {7'd0, irq}, 8'd0);
        sent = 0;
        for (int i = 0; i < n; i++) begin
            check8("R6 tx byte", eng_tx_byte, model[i]);
            eng_done = 1'b1; eng_nack_in = (i == refuse_at);
            @(negedge clk);
            eng_done = 1'b0; eng_nack_in = 1'b0;
            sent++;
            if (i == refuse_at) break;
        end
        end_checks(refuse_at >= 0 ? "R8 status" : "R7 status",
                   f_tx_status(refuse_at >= 0), 8'(sent));
        rd_dat(b);
        check8("R12 rewind", b, model[0]);
    endtask

    // Receive with count n; stop_at < 0 means run to the count.
    task automatic run_rx(int n, bit lb, int stop_at);
        logic [7:0] b;
        int got;
        wr_cnt({lb, 7'(n)});
        do_start(1'b1);
        check8("R5 busy", {7'd0, busy}, 8'd1);
        got = 0;
        for (int i = 0; i < n; i++) begin
            if (i == stop_at) begin
                eng_stop = 1'b1;
                @(negedge clk);
                eng_stop = 1'b0;
                break;
            end
            check8("R9 nack_out", {7'd0, eng_nack_out}, {7'd0, (lb && i == n - 1)});
            model[i] = 8'($urandom);
            eng_rx_byte = model[i]; eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
            got++;
        end
        end_checks(stop_at >= 0 ? "R11 status" : "R10 status",
                   f_rx_status(stop_at < 0, lb), {lb, 7'(got)});
        for (int i = 0; i < got; i++) begin
            rd_dat(b);
            check8("R9 rx data", b, model[i]);
        end
    endtask

    initial begin
        logic [7:0] b;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check8("R1 status", status, 8'hF8);
        check8("R1 irq", {7'd0, irq}, 8'd0);
        check8("R1 busy", {7'd0, busy}, 8'd0);
        check8("R1 count", host_cnt_rdata, 8'h00);
        // R2 count register
        wr_cnt(8'h85);
        check8("R2 readback", host_cnt_rdata, 8'h85);
        // R4 unusable counts
        wr_cnt(8'h00); do_start(1'b0);
        check8("R4 status zero", status, 8'hFC);
        check8("R4 irq", {7'd0, irq}, 8'd1);
        check8("R4 busy", {7'd0, busy}, 8'd0);
        wr_cnt(8'd69); do_start(1'b1);
        check8("R4 status 69", status, 8'hFC);
        check8("R4 busy 69", {7'd0, busy}, 8'd0);
        wr_cnt(8'hFF); do_start(1'b0);
        check8("R4 status 127", status, 8'hFC);
        // R3 surplus writes ignored, R2 count write rewinds
        wr_cnt(8'd4);
        wr_dat(8'h10); wr_dat(8'h11); wr_dat(8'h12); wr_dat(8'h13);
        wr_cnt(8'd3);
        wr_dat(8'hA1); wr_dat(8'hA2); wr_dat(8'hA3); wr_dat(8'hA4);
        wr_cnt(8'd4);
        rd_dat(b); check8("R3 byte0", b, 8'hA1);
        rd_dat(b); check8("R3 byte1", b, 8'hA2);
        rd_dat(b); check8("R3 byte2", b, 8'hA3);
        rd_dat(b); check8("R3 surplus ignored", b, 8'h13);
        // Directed transfer corners
        run_tx(1, -1);
        run_tx(DEPTH, -1);
        run_tx(5, 0);
        run_tx(6, 5);
        run_rx(DEPTH, 1'b1, -1);
        run_rx(1, 1'b1, -1);
        run_rx(1, 1'b0, -1);
        run_rx(8, 1'b0, 0);
        run_rx(8, 1'b1, 4);
        // Seeded random runs
        for (int k = 0; k < 12; k++) begin
            int n = 1 + int'($urandom % DEPTH);
            run_tx(n, ($urandom % 3 == 0) ? int'($urandom % n) : -1);
            n = 1 + int'($urandom % DEPTH);
            run_rx(n, bit'($urandom % 2), ($urandom % 3 == 0) ? int'($urandom % n) : -1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule